// File: doc/BRIEF.md
# Multiplexed ADC Scan Averaging Controller

This block runs a fixed, time-slotted scan over a bank of analog inputs that reach a single 12-bit parallel ADC through an external multiplexer. A divider turns the fast system clock into a timing tick. Every slot, the block selects one input channel by driving a group address and one active-low group select. It waits for the signal to settle, then captures a burst of evenly spaced ADC readings. The average of the burst is stored as that channel's entry in an internal result RAM.

Once the last channel's slot ends, all group selects go inactive until the frame boundary. The scan then restarts from channel 0 and a one-cycle frame strobe marks the restart. The block also supplies the ADC's conversion clock, divided down from the tick. A host reads any channel's latest result through a simple request/valid port at any time. Writes from the scan win over host reads.

Top module: `adc_scan_avg`

## Requirements
- R1: The selected channel advances by one every SLOT_TICKS ticks, one tick being TICK_DIV clock cycles. Outputs change only on a tick.
- R2: For active channel c, `mux_addr` = c mod 2^GRP_W and `mux_cs_n` has exactly bit (c >> GRP_W) low. At most one select is low at any time.
- R3: Within a slot, 2^SMP_LOG2 samples are captured, on the ticks where the slot tick count equals SETTLE_TICKS + k*GAP_TICKS (k = 0 .. 2^SMP_LOG2-1). Samples are captured on no other tick.
- R4: The stored result is the sum of the slot's samples, shifted right by SMP_LOG2 with the remainder dropped. The sum is held without overflow, so eight samples of 0xFFF store 0xFFF.
- R5: A host read with `rd_req` high in a cycle with no RAM write returns `rd_valid` high in the next cycle, with `rd_data` holding the last value written for `rd_addr`.
- R6: After the last channel's slot, all bits of `mux_cs_n` stay high until the frame boundary.
- R7: The scan restarts at channel 0 every FRAME_TICKS ticks. `frame_done` is high for exactly one cycle, in the first cycle of the new frame.
- R8: `adc_clk` has a period of ADC_DIV ticks and a 50% duty cycle. It is high for the first ADC_DIV/2 ticks after reset.
- R9: A host read issued in the cycle the scan writes the RAM is stalled by one cycle. `rd_valid` is low in the next cycle and high in the one after that, and the returned data is the value just written.
- R10: During and directly after reset, the block drives: channel 0 selected (`mux_addr` = 0, only `mux_cs_n[0]` low), `frame_done` = 0, `rd_valid` = 0, `adc_clk` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (48 MHz at default settings) |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_data | input | DATA_W | Parallel ADC conversion result |
| adc_clk | output | 1 | Conversion clock to the ADC |
| mux_addr | output | GRP_W | Address within the selected multiplexer group |
| mux_cs_n | output | N_GRP | Active-low select, one per group of 2^GRP_W inputs |
| frame_done | output | 1 | One-cycle strobe at each scan restart |
| rd_req | input | 1 | Host read request, single-cycle pulse |
| rd_addr | input | AW | Channel index to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Averaged result for the requested channel |

## Verification
The bench builds the block with shortened timing: TICK_DIV=2, SLOT_TICKS=40, SETTLE_TICKS=12, GAP_TICKS=3, FRAME_TICKS=500, ADC_DIV=4. It uses 10 channels in groups of 4, so the third group is only partly filled. With these values a full frame, including its idle tail, lasts 1000 cycles. The run can therefore cover several frames with different stimulus patterns, both group-boundary crossings, the idle gap and the frame restart.

The ADC input carries a distinct marker value at every tick that is not a sampling tick, so any sample taken at the wrong time changes the stored average. The dividers still run at a ratio of two, so behaviour that depends on the tick is exercised and not collapsed into every cycle.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  // Tick offset inside a slot at which burst sample k is captured.
  function automatic int unsigned sample_tick(input int unsigned settle,
                                              input int unsigned gap,
                                              input int unsigned k);
    return settle + k * gap;
  endfunction

  // Mean of a power-of-two burst: truncating right shift of the sum.
  function automatic logic [31:0] burst_mean(input logic [31:0] sum,
                                             input int unsigned lg);
    return sum >> lg;
  endfunction

endpackage

// File: rtl/adc_scan_tick.sv
module adc_scan_tick #(
  parameter int TICK_DIV = 2,
  parameter int ADC_DIV  = 24
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic adc_clk
);
  localparam int PH_W = (ADC_DIV > 2) ? $clog2(ADC_DIV) : 1;
  localparam int HALF = ADC_DIV / 2;

  generate
    if (TICK_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DV_W = $clog2(TICK_DIV);
      logic [DV_W-1:0] dv_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                              dv_q <= '0;
        else if (dv_q == DV_W'(TICK_DIV - 1))    dv_q <= '0;
        else                                     dv_q <= dv_q + 1'b1;
      end
      assign tick = (dv_q == DV_W'(TICK_DIV - 1));
    end
  endgenerate

  logic [PH_W-1:0] ph_q, ph_nxt;
  logic            clk_q;

  always_comb begin
    ph_nxt = (ph_q == PH_W'(ADC_DIV - 1)) ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= '0;
      clk_q <= 1'b1;
    end else if (tick) begin
      ph_q  <= ph_nxt;
      clk_q <= (ph_nxt < PH_W'(HALF));
    end
  end

  assign adc_clk = clk_q;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH       = 56,
  parameter int SLOT_TICKS   = 5280,
  parameter int SETTLE_TICKS = 2640,
  parameter int GAP_TICKS    = 240,
  parameter int FRAME_TICKS  = 480000,
  parameter int SMP_LOG2     = 3,
  parameter int CH_W         = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic [CH_W-1:0] ch,
  output logic            active,
  output logic            smp_strobe,
  output logic            smp_first,
  output logic            smp_last,
  output logic            frame_done
);
  localparam int FR_W = $clog2(FRAME_TICKS);
  localparam int SL_W = $clog2(SLOT_TICKS);
  localparam int SC_W = SMP_LOG2 + 1;
  localparam int NSMP = 1 << SMP_LOG2;

  logic [FR_W-1:0] fr_cnt;
  logic [SL_W-1:0] sl_cnt;
  logic [SC_W-1:0] smp_cnt;
  logic [CH_W-1:0] ch_q;
  logic            fr_wrap, sl_wrap, smp_due, done_q;

  assign fr_wrap = tick && (fr_cnt == FR_W'(FRAME_TICKS - 1));
  assign sl_wrap = tick && (sl_cnt == SL_W'(SLOT_TICKS - 1));
  assign active  = (ch_q < CH_W'(NUM_CH));
  assign smp_due = (smp_cnt < SC_W'(NSMP)) &&
                   (32'(sl_cnt) == sample_tick(SETTLE_TICKS, GAP_TICKS, 32'(smp_cnt)));

  assign smp_strobe = tick && active && smp_due;
  assign smp_first  = (smp_cnt == '0);
  assign smp_last   = (smp_cnt == SC_W'(NSMP - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fr_cnt  <= '0;
      sl_cnt  <= '0;
      smp_cnt <= '0;
      ch_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fr_wrap;
      if (tick) fr_cnt <= fr_wrap ? '0 : fr_cnt + 1'b1;
      if (fr_wrap) begin
        sl_cnt  <= '0;
        smp_cnt <= '0;
        ch_q    <= '0;
      end else if (sl_wrap) begin
        sl_cnt  <= '0;
        smp_cnt <= '0;
        if (active) ch_q <= ch_q + 1'b1;
      end else if (tick) begin
        sl_cnt <= sl_cnt + 1'b1;
        if (smp_strobe) smp_cnt <= smp_cnt + 1'b1;
      end
    end
  end

  assign ch         = ch_q;
  assign frame_done = done_q;
endmodule

// File: rtl/adc_scan_acc.sv
module adc_scan_acc
  import adc_scan_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int SMP_LOG2 = 3,
  parameter int AW       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_strobe,
  input  logic              smp_first,
  input  logic              smp_last,
  input  logic [DATA_W-1:0] adc_data,
  input  logic [AW-1:0]     ch,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int ACC_W = DATA_W + SMP_LOG2;

  logic [ACC_W-1:0] acc_q, acc_sum;
  logic [31:0]      mean;

  assign acc_sum = (smp_first ? '0 : acc_q) + ACC_W'(adc_data);
  assign mean    = burst_mean(32'(acc_sum), SMP_LOG2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= smp_strobe && smp_last;
      if (smp_strobe) acc_q <= acc_sum;
      if (smp_strobe && smp_last) begin
        wr_addr <= ch;
        wr_data <= mean[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/adc_scan_ram.sv
module adc_scan_ram #(
  parameter int DEPTH  = 56,
  parameter int DATA_W = 12,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_pend,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     pend_addr, sel_addr;
  logic              do_rd;

  assign do_rd    = (rd_req || rd_pend) && !wr_en;
  assign sel_addr = rd_pend ? pend_addr : rd_addr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      pend_addr <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_data <= mem[sel_addr];
      if (wr_en && rd_req && !rd_pend) begin
        rd_pend   <= 1'b1;
        pend_addr <= rd_addr;
      end else if (do_rd) begin
        rd_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_scan_avg.sv
module adc_scan_avg #(
  parameter int TICK_DIV     = 2,
  parameter int ADC_DIV      = 24,
  parameter int NUM_CH       = 56,
  parameter int GRP_W        = 3,
  parameter int SLOT_TICKS   = 5280,
  parameter int SETTLE_TICKS = 2640,
  parameter int GAP_TICKS    = 240,
  parameter int FRAME_TICKS  = 480000,
  parameter int DATA_W       = 12,
  parameter int SMP_LOG2     = 3,
  localparam int N_GRP       = (NUM_CH + (1 << GRP_W) - 1) >> GRP_W,
  localparam int AW          = (NUM_CH > 2) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_clk,
  output logic [GRP_W-1:0]  mux_addr,
  output logic [N_GRP-1:0]  mux_cs_n,
  output logic              frame_done,
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int CH_W = $clog2(NUM_CH + 1);

  logic            tick, active, smp_strobe, smp_first, smp_last;
  logic            wr_en, rd_pend;
  logic [CH_W-1:0] ch;
  logic [AW-1:0]   wr_addr;
  logic [DATA_W-1:0] wr_data;

  adc_scan_tick #(.TICK_DIV(TICK_DIV), .ADC_DIV(ADC_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick), .adc_clk(adc_clk)
  );

  adc_scan_seq #(
    .NUM_CH(NUM_CH), .SLOT_TICKS(SLOT_TICKS), .SETTLE_TICKS(SETTLE_TICKS),
    .GAP_TICKS(GAP_TICKS), .FRAME_TICKS(FRAME_TICKS), .SMP_LOG2(SMP_LOG2),
    .CH_W(CH_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ch(ch), .active(active),
    .smp_strobe(smp_strobe), .smp_first(smp_first), .smp_last(smp_last),
    .frame_done(frame_done)
  );

  adc_scan_acc #(.DATA_W(DATA_W), .SMP_LOG2(SMP_LOG2), .AW(AW)) u_acc (
    .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe), .smp_first(smp_first),
    .smp_last(smp_last), .adc_data(adc_data), .ch(ch[AW-1:0]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  adc_scan_ram #(.DEPTH(NUM_CH), .DATA_W(DATA_W), .AW(AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_pend(rd_pend), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Group decode: low address bits go to the mux, upper bits pick a select.
  assign mux_addr = ch[GRP_W-1:0];

  generate
    for (genvar g = 0; g < N_GRP; g++) begin : g_cs
      assign mux_cs_n[g] = !(active && ((ch >> GRP_W) == CH_W'(g)));
    end
  endgenerate
endmodule

// File: rtl/adc_scan_avg_chk.sv
module adc_scan_avg_chk #(
  parameter int N_GRP = 7,
  parameter int GRP_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             smp_strobe,
  input logic             smp_last,
  input logic             wr_en,
  input logic             rd_req,
  input logic             rd_pend,
  input logic             rd_valid,
  input logic             frame_done,
  input logic             adc_clk,
  input logic [GRP_W-1:0] mux_addr,
  input logic [N_GRP-1:0] mux_cs_n
);
  p_sel_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(mux_addr) && $stable(mux_cs_n)));

  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mux_cs_n));

  p_strobe_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |-> tick);

  p_write_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(smp_strobe && smp_last));

  p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wr_en && !rd_pend) |=> rd_valid);

  p_frame_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!mux_cs_n[0] && mux_addr == '0));

  p_frame_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_adc_clk_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(adc_clk));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && wr_en && !rd_pend) |=> (!rd_valid && rd_pend));

  p_stall_serve_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && wr_en && !rd_pend) |-> ##2 rd_valid);
endmodule

bind adc_scan_avg adc_scan_avg_chk #(.N_GRP(N_GRP), .GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .smp_strobe(smp_strobe),
  .smp_last(smp_last), .wr_en(wr_en), .rd_req(rd_req), .rd_pend(rd_pend),
  .rd_valid(rd_valid), .frame_done(frame_done), .adc_clk(adc_clk),
  .mux_addr(mux_addr), .mux_cs_n(mux_cs_n)
);

// File: tb/adc_scan_avg_tb_top.sv
`timescale 1ns/1ps
module adc_scan_avg_tb_top;
  localparam int TD  = 2;
  localparam int AD  = 4;
  localparam int NCH = 10;
  localparam int GW  = 2;
  localparam int SL  = 40;
  localparam int ST  = 12;
  localparam int GP  = 3;
  localparam int FR  = 500;
  localparam int NGR = 3;
  localparam int AWB = 4;
  localparam int IDLE_CYC = (FR - NCH * SL) * TD;
  localparam int LAST_T   = (ST + 7 * GP) * TD + TD - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [11:0]    adc_data = '0;
  logic           adc_clk, frame_done, rd_valid;
  logic [GW-1:0]  mux_addr;
  logic [NGR-1:0] mux_cs_n;
  logic           rd_req = 1'b0;
  logic [AWB-1:0] rd_addr = '0;
  logic [11:0]    rd_data;

  int errors = 0;
  int checks = 0;
  int seed   = 0;
  int cur_ch = 0;
  int t      = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  adc_scan_avg #(
    .TICK_DIV(TD), .ADC_DIV(AD), .NUM_CH(NCH), .GRP_W(GW), .SLOT_TICKS(SL),
    .SETTLE_TICKS(ST), .GAP_TICKS(GP), .FRAME_TICKS(FR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .adc_clk(adc_clk),
    .mux_addr(mux_addr), .mux_cs_n(mux_cs_n), .frame_done(frame_done),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Value of burst sample k for a given pattern and channel.
  function automatic int pat(input int s, input int c, input int k);
    case (s)
      0:       return (c * 311 + k * 57 + 5) & 12'hFFF;
      1:       return 12'hFFF;
      2:       return (k % 2 == 1) ? 12'hFFF : 0;
      default: return (c * 401 + k * k * 29 + 100) & 12'hFFF;
    endcase
  endfunction

  function automatic int exp_avg(input int s, input int c);
    int sum = 0;
    for (int k = 0; k < 8; k++) sum += pat(s, c, k);
    return sum / 8;
  endfunction

  // Cycle t after a selection change maps to a sample only on these cycles.
  function automatic logic [11:0] stim(input int s, input int c, input int tt);
    int base = ST * TD + TD - 1;
    if (c < 0 || tt < base || ((tt - base) % (GP * TD)) != 0) return 12'h5A5;
    if ((tt - base) / (GP * TD) >= 8) return 12'h5A5;
    return 12'(pat(s, c, (tt - base) / (GP * TD)));
  endfunction

  function automatic int decode_sel();
    for (int g = 0; g < NGR; g++)
      if (!mux_cs_n[g]) return g * (1 << GW) + int'(mux_addr);
    return -1;
  endfunction

  // Tracks time since the last selection change and drives the ADC input.
  always @(negedge clk) begin
    int c;
    c = decode_sel();
    if (!rst_n || c != cur_ch) t = 0;
    else t++;
    cur_ch = c;
    adc_data = stim(seed, cur_ch, t);
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic test_reset();
    check(mux_addr == 0, "R10 mux_addr", int'(mux_addr), 0);
    check(mux_cs_n == 3'b110, "R10 mux_cs_n", int'(mux_cs_n), 6);
    check(frame_done == 0, "R10 frame_done", int'(frame_done), 0);
    check(rd_valid == 0, "R10 rd_valid", int'(rd_valid), 0);
    check(adc_clk == 1, "R10 adc_clk", int'(adc_clk), 1);
  endtask

  // Follows one full frame: slot lengths, decode, idle gap, restart strobe.
  task automatic test_scan_frame();
    int prev = 0, run = 1, e = 0, pulses = 0;
    bit restarted = 0;
    for (int i = 0; i < FR * TD + 6; i++) begin
      step();
      if (frame_done) pulses++;
      if (cur_ch != prev && !restarted) begin
        if (prev >= 0) begin
          check(run == SL * TD, "R1 slot length", run, SL * TD);
          e = (prev + 1 < NCH) ? prev + 1 : -1;
        end else begin
          check(run == IDLE_CYC, "R6 idle length", run, IDLE_CYC);
          check(frame_done == 1, "R7 strobe at restart", int'(frame_done), 1);
          e = 0;
          restarted = 1;
        end
        if (e >= 0) begin
          check(int'(mux_addr) == e % 4, "R2 mux_addr", int'(mux_addr), e % 4);
          check(int'(mux_cs_n) == (~(1 << (e / 4)) & 7), "R2 mux_cs_n",
                int'(mux_cs_n), ~(1 << (e / 4)) & 7);
        end else begin
          check(mux_cs_n == 3'b111, "R6 selects idle", int'(mux_cs_n), 7);
        end
        prev = cur_ch;
        run = 1;
      end else begin
        run++;
      end
    end
    check(pulses == 1, "R7 one strobe per frame", pulses, 1);
    // Frame period: next strobe arrives FR*TD cycles after this one.
    run = 0;
    while (!frame_done && run < FR * TD + 10) begin
      step();
      run++;
    end
    check(run == FR * TD - 6, "R7 frame period", run + 6, FR * TD);
    step();
    check(frame_done == 0, "R7 strobe width", int'(frame_done), 0);
  endtask

  task automatic host_read(input int c, output int data, output bit ok);
    rd_addr = AWB'(c);
    rd_req  = 1'b1;
    step();
    rd_req  = 1'b0;
    ok      = rd_valid;
    data    = int'(rd_data);
    step();
  endtask

  // Waits for the idle gap, reads every channel, then switches the pattern.
  task automatic test_results(input int s, input int next_s);
    int d;
    bit ok;
    while (cur_ch == -1) step();
    while (cur_ch != -1) step();
    for (int c = 0; c < NCH; c++) begin
      host_read(c, d, ok);
      check(ok, "R5 read valid after one cycle", int'(ok), 1);
      check(d == exp_avg(s, c), (s == 1) ? "R4 full-scale average" :
            (s == 2) ? "R4 truncated average" : "R3 sample timing average",
            d, exp_avg(s, c));
    end
    seed = next_s;
  endtask

  task automatic test_collision(input int c);
    while (!(cur_ch == c && t == LAST_T + 1)) step();
    rd_addr = AWB'(c);
    rd_req  = 1'b1;
    step();
    rd_req  = 1'b0;
    check(rd_valid == 0, "R9 read stalled", int'(rd_valid), 0);
    step();
    check(rd_valid == 1, "R9 stalled read served", int'(rd_valid), 1);
    check(int'(rd_data) == exp_avg(seed, c), "R9 returns new value",
          int'(rd_data), exp_avg(seed, c));
  endtask

  task automatic test_adc_clk();
    int hi = 0, lo = 0;
    bit prev;
    prev = adc_clk;
    while (!(prev == 0 && adc_clk == 1)) begin
      prev = adc_clk;
      step();
    end
    while (adc_clk == 1) begin hi++; step(); end
    while (adc_clk == 0) begin lo++; step(); end
    check(hi == AD * TD / 2, "R8 adc_clk high time", hi, AD * TD / 2);
    check(lo == AD * TD / 2, "R8 adc_clk low time", lo, AD * TD / 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    @(negedge clk);
    #1 rst_n = 1'b1;
    test_scan_frame();
    test_results(0, 1);
    test_results(1, 2);
    test_results(2, 3);
    test_collision(5);
    test_adc_clk();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule